// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Flags

This block is a synchronous two-port RAM whose ports, A and B, share one clock and may each read or write any word in any cycle. Alongside the stored data, each port has a collision flag. The flag tells that port that the other port touched the same word in the same cycle, in a way that makes this port's result unreliable.

A read that meets a write on the other port flags only the reader, because its returned word may be stale. Two writes to one word flag both writers, because either value may survive. Two reads to one word flag no one. The flag only reports what happened. Both accesses still complete, so bursts run at full rate while flags are being reported.

Read data is registered and is valid one cycle after the access. The collision flag is pipelined through two registers. It is high during the second cycle after the colliding access, which is one cycle after the read data of that access.

Top module: `twinport_clash_ram`

## Requirements
- R1: A flag is raised only when both ports are enabled in the same cycle with equal addresses. Accesses to different addresses never raise a flag.
- R2: When both ports read the same address in the same cycle, neither `a_clash` nor `b_clash` is raised.
- R3: When port A reads (`a_en`=1, `a_we`=0) and port B writes the same address in the same cycle, only `a_clash` is raised.
- R4: When port B reads and port A writes the same address in the same cycle, only `b_clash` is raised.
- R5: When both ports write the same address in the same cycle, both flags are raised. The word then holds the data of one of the two ports.
- R6: A port with its enable low neither causes a flag on the other port nor receives one.
- R7: A flag is high in the second cycle after the colliding access (after two rising edges), for exactly one cycle per colliding cycle. Back-to-back collisions give an unbroken run of flags of the same length.
- R8: Both flags are active high and are forced low at once while `rst_n` is low. The read data registers also clear to zero.
- R9: A read returns, one cycle later, the word stored before that cycle's writes. The read data holds its value in cycles without a read by that port. Writes always complete, including in colliding cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, one cycle after the read |
| a_clash | output | 1 | Port A collision flag |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, one cycle after the read |
| b_clash | output | 1 | Port B collision flag |

## Verification
The hardest situation to reach is an unbroken run of collisions whose read/write mix changes from one cycle to the next, while flags from earlier cycles are still moving through the pipeline. Only that overlap shows a flag landing in the wrong cycle or on the wrong port. The stimulus reaches it with directed back-to-back runs of mixed collisions. It then adds a long random burst confined to four addresses with random enables, so collisions of every kind arrive densely and in arbitrary order. A reset asserted while a flag is in flight confirms that the pipeline is cleared.

// File: rtl/clash_pkg.sv
package clash_pkg;

  localparam int CLASH_LAT = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef struct packed {
    logic a;
    logic b;
  } flag_pair_t;

  function automatic op_e op_of(input logic en, input logic we);
    if (!en) return OP_IDLE;
    return we ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/clash_rst_sync.sv
module clash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/clash_classify.sv
module clash_classify
  import clash_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output flag_pair_t        hit
);
  op_e  op_a;
  op_e  op_b;
  logic same_word;

  assign op_a      = op_of(a_en, a_we);
  assign op_b      = op_of(b_en, b_we);
  assign same_word = (a_addr == b_addr);

  // A port is endangered whenever the other port writes its word.
  always_comb begin
    hit = '0;
    if (same_word && (op_a != OP_IDLE) && (op_b != OP_IDLE)) begin
      hit.a = (op_b == OP_WRITE);
      hit.b = (op_a == OP_WRITE);
    end
  end
endmodule

// File: rtl/clash_flag_pipe.sv
module clash_flag_pipe
  import clash_pkg::*;
#(
  parameter int STAGES = CLASH_LAT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  flag_pair_t hit_i,
  output flag_pair_t hit_o
);
  flag_pair_t stage_q [STAGES];
  flag_pair_t stage_d [STAGES];

  always_comb begin
    stage_d[0] = hit_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign hit_o = stage_q[STAGES-1];
endmodule

// File: rtl/clash_mem.sv
module clash_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] store [DEPTH];
  logic              a_rd, b_rd, a_wr, b_wr;
  logic [DATA_W-1:0] a_rd_d, b_rd_d, a_rd_q, b_rd_q;

  assign a_rd = a_en & ~a_we;
  assign b_rd = b_en & ~b_we;
  assign a_wr = a_en &  a_we;
  assign b_wr = b_en &  b_we;

  // Port B is applied last, so it wins a same-word double write.
  always_ff @(posedge clk) begin
    if (a_wr) store[a_addr] <= a_wdata;
    if (b_wr) store[b_addr] <= b_wdata;
  end

  always_comb begin
    a_rd_d = a_rd ? store[a_addr] : a_rd_q;
    b_rd_d = b_rd ? store[b_addr] : b_rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rd_q <= '0;
      b_rd_q <= '0;
    end else begin
      a_rd_q <= a_rd_d;
      b_rd_q <= b_rd_d;
    end
  end

  assign a_rdata = a_rd_q;
  assign b_rdata = b_rd_q;
endmodule

// File: rtl/twinport_clash_ram.sv
module twinport_clash_ram
  import clash_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_clash,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_clash
);
  logic       rst_q_n;
  flag_pair_t hit_now;
  flag_pair_t hit_late;

  clash_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  clash_classify #(.ADDR_W(ADDR_W)) u_cls (
    .a_en   (a_en),
    .a_we   (a_we),
    .a_addr (a_addr),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_addr (b_addr),
    .hit    (hit_now)
  );

  clash_flag_pipe #(.STAGES(CLASH_LAT)) u_pipe (
    .clk   (clk),
    .rst_n (rst_q_n),
    .hit_i (hit_now),
    .hit_o (hit_late)
  );

  clash_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  assign a_clash = hit_late.a;
  assign b_clash = hit_late.b;
endmodule

// File: rtl/clash_checker.sv
module clash_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_clash,
  input logic              b_clash
);
  logic [2:0] age_q;
  logic       live;
  logic       same, rr, a_rd_b_wr, b_rd_a_wr, ww, apart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign live = (age_q == 3'd7);

  assign same      = a_en && b_en && (a_addr == b_addr);
  assign rr        = same && !a_we && !b_we;
  assign a_rd_b_wr = same && !a_we &&  b_we;
  assign b_rd_a_wr = same &&  a_we && !b_we;
  assign ww        = same &&  a_we &&  b_we;
  assign apart     = a_en && b_en && (a_addr != b_addr);

  // R1: distinct addresses never flag
  a_r1_apart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(apart, 2)) |-> (!a_clash && !b_clash));

  // R2: two readers are left alone
  a_r2_read_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(rr, 2)) |-> (!a_clash && !b_clash));

  // R3
  a_r3_a_reader_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(a_rd_b_wr, 2)) |-> (a_clash && !b_clash));

  // R4
  a_r4_b_reader_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(b_rd_a_wr, 2)) |-> (b_clash && !a_clash));

  // R5
  a_r5_both_writers_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(ww, 2)) |-> (a_clash && b_clash));

  // R6, R7: a flag always traces back to a same-word access two edges earlier
  a_r6_flag_has_cause_a: assert property (@(posedge clk) disable iff (!rst_n)
    (live && a_clash) |-> $past(same, 2));
  a_r6_flag_has_cause_b: assert property (@(posedge clk) disable iff (!rst_n)
    (live && b_clash) |-> $past(same, 2));

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_clears: assert (!a_clash && !b_clash);
    end
  end
endmodule

bind twinport_clash_ram clash_checker #(.ADDR_W(ADDR_W)) u_clash_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_addr  (a_addr),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_addr  (b_addr),
  .a_clash (a_clash),
  .b_clash (b_clash)
);

// File: tb/twinport_clash_ram_bench.sv
`timescale 1ns/100ps
module twinport_clash_ram_bench;
  localparam int DW    = 16;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_clash, b_clash;

  always #2.5 clk = ~clk;

  twinport_clash_ram #(.DATA_W(DW), .DEPTH(DEPTH)) u_twinport_clash_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_clash(a_clash),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_clash(b_clash)
  );

  int    checks = 0;
  int    errors = 0;
  string tag    = "R8";

  // reference model state
  logic [DW-1:0] m0 [DEPTH];
  logic [DW-1:0] m1 [DEPTH];
  bit            known [DEPTH];
  bit pa0, pa1, pb0, pb1;
  bit            ra_ok, rb_ok;
  logic [DW-1:0] ra0, ra1, rb0, rb1;

  task automatic check_bit(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic check_word(string t, string what, logic [DW-1:0] act,
                            logic [DW-1:0] e0, logic [DW-1:0] e1);
    checks++;
    if (act !== e0 && act !== e1) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h or %h at %0t", t, what, act, e0, e1, $time);
    end
  endtask

  task automatic compare_all();
    check_bit(tag, "a_clash", a_clash, pa1);
    check_bit(tag, "b_clash", b_clash, pb1);
    if (ra_ok) check_word("R9", "a_rdata", a_rdata, ra0, ra1);
    if (rb_ok) check_word("R9", "b_rdata", b_rdata, rb0, rb1);
  endtask

  task automatic model_edge();
    bit same, ca, cb;
    same = a_en && b_en && (a_addr == b_addr);
    ca = same && b_we;
    cb = same && a_we;
    pa1 = pa0; pa0 = ca;
    pb1 = pb0; pb0 = cb;
    if (a_en && !a_we) begin
      ra_ok = known[a_addr] && !ca;
      ra0 = m0[a_addr]; ra1 = m1[a_addr];
    end
    if (b_en && !b_we) begin
      rb_ok = known[b_addr] && !cb;
      rb0 = m0[b_addr]; rb1 = m1[b_addr];
    end
    if (a_en && a_we && b_en && b_we && a_addr == b_addr) begin
      m0[a_addr] = a_wdata; m1[a_addr] = b_wdata; known[a_addr] = 1'b1;
    end else begin
      if (a_en && a_we) begin m0[a_addr] = a_wdata; m1[a_addr] = a_wdata; known[a_addr] = 1'b1; end
      if (b_en && b_we) begin m0[b_addr] = b_wdata; m1[b_addr] = b_wdata; known[b_addr] = 1'b1; end
    end
  endtask

  task automatic step(input logic ae, input logic awe, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic be, input logic bwe, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    summary_and_end();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin known[i] = 0; m0[i] = '0; m1[i] = '0; end
    pa0 = 0; pa1 = 0; pb0 = 0; pb1 = 0;
    ra_ok = 1; rb_ok = 1; ra0 = '0; ra1 = '0; rb0 = '0; rb1 = '0;
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    repeat (4) @(posedge clk);
    #1;
    tag = "R8";
    check_bit("R8", "a_clash in reset", a_clash, 1'b0);
    check_bit("R8", "b_clash in reset", b_clash, 1'b0);
    check_word("R8", "a_rdata in reset", a_rdata, '0, '0);
    check_word("R8", "b_rdata in reset", b_rdata, '0, '0);
    rst_n = 1'b1;
    idle(4);

    // R1: fill with writes to distinct addresses from both ports
    tag = "R1";
    for (int i = 0; i < 16; i++)
      step(1, 1, AW'(i), DW'(16'h1000 + i), 1, 1, AW'(i + 32), DW'(16'h2000 + i));
    // R1, R9: reads at distinct addresses
    for (int i = 0; i < 8; i++)
      step(1, 0, AW'(i + 32), '0, 1, 0, AW'(i), '0);
    idle(3);

    // R2: both read one word
    tag = "R2";
    step(1, 0, AW'(5), '0, 1, 0, AW'(5), '0);
    idle(3);

    // R3: A reads, B writes the same word
    tag = "R3";
    step(1, 0, AW'(6), '0, 1, 1, AW'(6), 16'hB006);
    idle(3);
    tag = "R9";
    step(1, 0, AW'(6), '0, 0, 0, '0, '0);
    idle(2);

    // R4: B reads, A writes the same word
    tag = "R4";
    step(1, 1, AW'(7), 16'hA007, 1, 0, AW'(7), '0);
    idle(3);
    tag = "R9";
    step(0, 0, '0, '0, 1, 0, AW'(7), '0);
    idle(2);

    // R5: both write the same word; either value may survive
    tag = "R5";
    step(1, 1, AW'(8), 16'hAAA8, 1, 1, AW'(8), 16'hBBB8);
    idle(3);
    step(1, 0, AW'(8), '0, 1, 0, AW'(8), '0);
    idle(2);

    // R6: a disabled port at the same address with a write on the other
    tag = "R6";
    step(0, 0, AW'(9), '0, 1, 1, AW'(9), 16'hB009);
    step(1, 1, AW'(9), 16'hA009, 0, 0, AW'(9), '0);
    step(0, 1, AW'(9), 16'hDEAD, 1, 0, AW'(9), '0);
    idle(3);

    // R7: back-to-back collision run with a changing mix, then a gap
    tag = "R7";
    step(1, 1, AW'(10), 16'h0A10, 1, 0, AW'(10), '0);
    step(1, 0, AW'(11), '0, 1, 1, AW'(11), 16'h0B11);
    step(1, 1, AW'(12), 16'h0A12, 1, 1, AW'(12), 16'h0B12);
    step(1, 0, AW'(12), '0, 1, 0, AW'(12), '0);
    step(1, 1, AW'(13), 16'h0A13, 1, 0, AW'(13), '0);
    idle(4);

    // mixed random burst on four addresses
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], AW'(r[5:4]), r[31:16],
           r[8] | r[9], r[10], AW'(r[13:12]), ~r[31:16]);
    end
    idle(3);

    // R8: reset while a flag is in flight
    tag = "R8";
    step(1, 1, AW'(20), 16'h1111, 1, 1, AW'(20), 16'h2222);
    rst_n = 1'b0;
    #1;
    pa0 = 0; pa1 = 0; pb0 = 0; pb1 = 0;
    ra_ok = 1; rb_ok = 1; ra0 = '0; ra1 = '0; rb0 = '0; rb1 = '0;
    a_en = 0; b_en = 0; a_we = 0; b_we = 0;
    check_bit("R8", "a_clash after async reset", a_clash, 1'b0);
    check_bit("R8", "b_clash after async reset", b_clash, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    check_bit("R8", "a_clash held in reset", a_clash, 1'b0);
    rst_n = 1'b1;
    idle(5);

    summary_and_end();
  end
endmodule